// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block turns a stream of parallel 24-bit signed audio samples into a three-wire serial stream: a bit clock, a word clock and a data line. It divides the system clock down to the bit clock. Each output word fills 32 bit-clock slots, and the sample is sent most significant bit first, starting in slot 0. Slots past the end of the selected word length carry zero.

Four run-time codes set the format. A size code picks 16, 18, 20 or 24 bits, and the block keeps the most significant bits of each sample. An oversampling code picks the bit-clock rate, which sets the word period. A polarity bit picks which word-clock edge marks the start of a word. A format bit picks two's complement or complementary offset binary. In complementary offset binary, every kept bit except the MSB is inverted.

The upstream source is asked for one sample per word period through a ready/valid handshake. A word whose load cycle finds no valid sample carries a formatted zero. The codes are sampled in that same load cycle, so a change made partway through a word takes effect only at the next word.

Top module: `pcm_serial_tx`

## Requirements
- R1: `size_i` selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24.
- R2: Truncation keeps the top bits of `sample_i`. Every slot from the word length up to slot 31 carries 0 on `sdo_o`.
- R3: When `cob_i`=1, every kept bit below the MSB is inverted and the MSB is sent unchanged. When `cob_i`=0, the truncated two's complement bits are sent as they are.
- R4: `osr_i` sets the bit-clock period in system clocks: code 1 gives 8, code 2 gives 4, and codes 3 and 0 give 2. A word period is always 32 bit-clock periods.
- R5: In each word, `wck_o` is equal to the latched `wpol_i` during slots 0 to 15 and to its inverse during slots 16 to 31. So with `wpol_i`=0 a word starts on a falling edge of `wck_o`, and with `wpol_i`=1 on a rising edge. `wck_o` changes only where `bck_o` falls.
- R6: `bck_o` is low in the first half of each slot and high in the second half. `sdo_o` changes only in the cycle where `bck_o` falls. Slot 0 of a word carries bit 23 of the formatted word.
- R7: `ready_o` is high for exactly one system clock, the last one, in each word period. The handshake is `ready_o`&&`valid_i` at that clock edge, and the next word starts in the following cycle.
- R8: If `valid_i` is low in the load cycle, the value on `sample_i` is ignored and the next word carries a zero sample formatted with the current codes.
- R9: `size_i`, `osr_i`, `wpol_i` and `cob_i` are sampled only in the load cycle. Changing them partway through a word does not alter that word.
- R10: While `rst_ni` is low: `ready_o`=1, `bck_o`=1, `wck_o`=1 and `sdo_o`=0. The first load happens on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 24 | Signed input sample |
| valid_i | input | 1 | Sample on `sample_i` is valid |
| ready_o | output | 1 | Load cycle: a sample is taken at this clock edge |
| size_i | input | 2 | Word length code |
| osr_i | input | 2 | Oversampling rate code |
| wpol_i | input | 1 | Word-clock boundary edge: 0 falling, 1 rising |
| cob_i | input | 1 | 0 two's complement, 1 complementary offset binary |
| bck_o | output | 1 | Bit clock |
| wck_o | output | 1 | Word clock |
| sdo_o | output | 1 | Serial data, MSB first |

## Verification
The assertions check the timing rules on every cycle:
- data and word-clock changes line up with bit-clock falling edges;
- the bit-clock half-period stays within its bound;
- the load strobe is one cycle wide;
- each word opens with the word-clock level given by the polarity;
- the slots past the sample width stay silent.

Only the bench scenarios can show that bit values are right, since that needs a model of truncation and format conversion. The bench compares every cycle of every word against that model for each size, format, rate and polarity. It also covers underrun words and codes changed partway through a word.

// File: rtl/pcm_serial_tx_pkg.sv
`timescale 1ns/1ps
package pcm_serial_tx_pkg;

  localparam int unsigned OSR_MAX_SH = 2;

  typedef struct packed {
    logic [1:0] osr;
    logic       wpol;
  } tim_cfg_t;

  localparam tim_cfg_t TIM_CFG_RST = '{osr: 2'd3, wpol: 1'b0};

  // bits dropped from a 24-bit sample for each size code
  function automatic logic [3:0] drop_bits(input logic [1:0] code);
    case (code)
      2'd0:    drop_bits = 4'd8;
      2'd1:    drop_bits = 4'd6;
      2'd2:    drop_bits = 4'd4;
      default: drop_bits = 4'd0;
    endcase
  endfunction

  // log2 of system clocks per bit-clock half period; code 0 aliases code 3
  function automatic logic [1:0] osr_shift(input logic [1:0] code);
    case (code)
      2'd1:    osr_shift = 2'd2;
      2'd2:    osr_shift = 2'd1;
      default: osr_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pcm_tx_timing.sv
`timescale 1ns/1ps
module pcm_tx_timing
  import pcm_serial_tx_pkg::*;
#(
  parameter int unsigned SLOTS = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  tim_cfg_t                 cfg_i,
  output logic                     load_o,
  output logic                     bck_o,
  output logic                     wck_o,
  output logic [$clog2(SLOTS)-1:0] slot_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = SLOT_W + 1 + OSR_MAX_SH;
  localparam int unsigned IDX_W  = $clog2(CNT_W);

  tim_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sh;
  logic [CNT_W:0]   span;
  logic [IDX_W-1:0] bck_idx, wck_idx;

  assign sh      = osr_shift(cfg_q.osr);
  assign span    = (CNT_W+1)'(2 * SLOTS) << sh;
  assign load_o  = (cnt_q == CNT_W'(span - 1'b1));
  assign bck_idx = IDX_W'(sh);
  assign wck_idx = IDX_W'(sh) + IDX_W'(SLOT_W);
  assign bck_o   = cnt_q[bck_idx];
  assign wck_o   = cnt_q[wck_idx] ^ cfg_q.wpol;
  assign slot_o  = SLOT_W'(cnt_q >> (sh + 2'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= TIM_CFG_RST;
      cnt_q <= CNT_W'(2 * SLOTS - 1);
    end else if (load_o) begin
      cfg_q <= cfg_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_format.sv
`timescale 1ns/1ps
module pcm_tx_format
  import pcm_serial_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  input  logic [1:0]          size_i,
  input  logic                cob_i,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam int unsigned CUT_W = $clog2(SAMPLE_W + 1);

  logic [CUT_W-1:0]    cut;
  logic [SAMPLE_W-1:0] raw;

  assign cut = CUT_W'(drop_bits(size_i)) + CUT_W'(SAMPLE_W - 24);
  assign raw = valid_i ? sample_i : '0;

  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_bit
    if (i == SAMPLE_W - 1) begin : g_msb
      assign word_o[i] = raw[i];
    end else begin : g_low
      assign word_o[i] = (CUT_W'(i) >= cut) & (raw[i] ^ cob_i);
    end
  end
endmodule

// File: rtl/pcm_tx_shreg.sv
`timescale 1ns/1ps
module pcm_tx_shreg #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOTS    = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [SAMPLE_W-1:0]      word_i,
  input  logic [$clog2(SLOTS)-1:0] slot_i,
  output logic                     sdo_o
);
  logic [SAMPLE_W-1:0] word_q;
  logic [SAMPLE_W-1:0] aligned;

  // shifting by slot >= SAMPLE_W leaves zero, which gives the silent tail
  assign aligned = word_q << slot_i;
  assign sdo_o   = aligned[SAMPLE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end
endmodule

// File: rtl/pcm_serial_tx.sv
`timescale 1ns/1ps
module pcm_serial_tx
  import pcm_serial_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOTS    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [1:0]          size_i,
  input  logic [1:0]          osr_i,
  input  logic                wpol_i,
  input  logic                cob_i,
  output logic                bck_o,
  output logic                wck_o,
  output logic                sdo_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  tim_cfg_t            tcfg;
  logic                load;
  logic [SLOT_W-1:0]   slot;
  logic [SAMPLE_W-1:0] fmt_word;

  assign tcfg    = '{osr: osr_i, wpol: wpol_i};
  assign ready_o = load;

  pcm_tx_timing #(.SLOTS(SLOTS)) u_timing (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (tcfg),
    .load_o(load),
    .bck_o (bck_o),
    .wck_o (wck_o),
    .slot_o(slot)
  );

  pcm_tx_format #(.SAMPLE_W(SAMPLE_W)) u_format (
    .sample_i(sample_i),
    .valid_i (valid_i),
    .size_i  (size_i),
    .cob_i   (cob_i),
    .word_o  (fmt_word)
  );

  pcm_tx_shreg #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_shreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(fmt_word),
    .slot_i(slot),
    .sdo_o (sdo_o)
  );
endmodule

// File: rtl/pcm_serial_tx_chk.sv
`timescale 1ns/1ps
module pcm_serial_tx_chk #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic wpol_i,
  input logic bck_o,
  input logic wck_o,
  input logic sdo_o
);
  logic       bck_q;
  logic [5:0] fall_cnt;
  logic [2:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_q    <= 1'b1;
      fall_cnt <= '0;
      hold_cnt <= '0;
    end else begin
      bck_q <= bck_o;
      if (ready_o)                                   fall_cnt <= '0;
      else if (bck_q && !bck_o && fall_cnt != 6'h3f) fall_cnt <= fall_cnt + 1'b1;
      if (bck_o != bck_q)       hold_cnt <= '0;
      else if (hold_cnt != 3'h7) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  AST_SDO_ON_BCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $fell(bck_o)); // R6
  AST_WORD_STARTS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> $fell(bck_o)); // R6
  AST_WCK_ON_BCK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wck_o) |-> $fell(bck_o)); // R5
  AST_WCK_START_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (wck_o == $past(wpol_i))); // R5
  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R7
  AST_TAIL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_cnt > 6'(SAMPLE_W)) |-> !sdo_o); // R2
  AST_BCK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt <= 3'd3); // R4
endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ready_o(ready_o),
  .wpol_i (wpol_i),
  .bck_o  (bck_o),
  .wck_o  (wck_o),
  .sdo_o  (sdo_o)
);

// File: tb/pcm_serial_tx_test.sv
`timescale 1ns/1ps
module pcm_serial_tx_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] sample_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [1:0]  size_i = 2'd3;
  logic [1:0]  osr_i = 2'd3;
  logic        wpol_i = 1'b0;
  logic        cob_i = 1'b0;
  logic        bck_o, wck_o, sdo_o;

  always #2.5 clk = ~clk;

  pcm_serial_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .valid_i(valid_i),
    .ready_o(ready_o), .size_i(size_i), .osr_i(osr_i), .wpol_i(wpol_i),
    .cob_i(cob_i), .bck_o(bck_o), .wck_o(wck_o), .sdo_o(sdo_o)
  );

  typedef struct {
    logic [31:0] bits;
    int          sh;
    logic        pol;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    k = 0;
  bit    active = 0;
  bit    bad = 0;
  int    bad_k = 0;
  logic [3:0] bad_act, bad_exp;
  int    tests = 0, fails = 0, pushed = 0, done = 0;

  function automatic logic [23:0] model(logic [23:0] s, logic [1:0] size, logic c);
    int len;
    logic [23:0] mask;
    case (size)
      2'd0: len = 16;
      2'd1: len = 18;
      2'd2: len = 20;
      default: len = 24;
    endcase
    mask = '0;
    for (int i = 0; i < 24; i++) if (i >= 24 - len) mask[i] = 1'b1;
    model = s & mask;
    if (c) model = model ^ (mask & 24'h7fffff);
  endfunction

  function automatic int sh_of(logic [1:0] osr);
    case (osr)
      2'd1: sh_of = 2;
      2'd2: sh_of = 1;
      default: sh_of = 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // driver: present one sample and codes, push the expected word, wait for its load edge
  task automatic send(logic [23:0] s, logic v, logic [1:0] size, logic [1:0] osr,
                      logic pol, logic c, string tag);
    item_t it;
    sample_i = s;
    valid_i  = v;
    size_i   = size;
    osr_i    = osr;
    wpol_i   = pol;
    cob_i    = c;
    it.bits  = {model(v ? s : 24'h0, size, c), 8'h00};
    it.sh    = sh_of(osr);
    it.pol   = pol;
    it.tag   = tag;
    q.push_back(it);
    pushed++;
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // monitor: cycle-by-cycle compare of the current word against its expected item
  always @(negedge clk) begin
    if (rst_ni && active) begin
      int wc;
      int slot;
      logic [3:0] ex, ac;
      wc   = 64 << cur.sh;
      slot = k >> (cur.sh + 1);
      ex   = {k == wc - 1, 1'((k >> cur.sh) & 1), 1'(((k >> (cur.sh + 5)) & 1) ^ int'(cur.pol)),
              cur.bits[31 - slot]};
      ac   = {ready_o, bck_o, wck_o, sdo_o};
      if (ac !== ex && !bad) begin
        bad = 1; bad_k = k; bad_act = ac; bad_exp = ex;
      end
      k++;
      if (k == wc) begin
        check(!bad, cur.tag, $sformatf("word %0d cycle %0d {rdy,bck,wck,sdo}", done, bad_k),
              32'(bad_act), 32'(bad_exp));
        done++;
        active = 0;
      end
    end
    if (rst_ni && ready_o) begin
      if (q.size() > 0) begin
        cur = q.pop_front();
        k = 0; active = 1; bad = 0;
      end
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=%0d words", done, pushed);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset levels
    check(ready_o === 1'b1, "R10", "ready_o in reset", 32'(ready_o), 1);
    check(bck_o === 1'b1, "R10", "bck_o in reset", 32'(bck_o), 1);
    check(wck_o === 1'b1, "R10", "wck_o in reset", 32'(wck_o), 1);
    check(sdo_o === 1'b0, "R10", "sdo_o in reset", 32'(sdo_o), 0);
    @(posedge clk);
    #1;
    rst_ni = 1'b1;
    // R1 R2 R3: every size in both formats at 8x rate
    for (int sz = 0; sz < 4; sz++) begin
      send(24'h9abcdf, 1, 2'(sz), 2'd3, 1'b0, 1'b0, "R1 R2");
      send(24'h3579bd, 1, 2'(sz), 2'd3, 1'b0, 1'b1, "R1 R3");
      send(24'h800001, 1, 2'(sz), 2'd3, 1'b0, 1'b1, "R3 R2");
    end
    // R4 rates, code 0 aliases code 3; R5 both polarities; R9 codes change mid-word
    send(24'hc0ffee, 1, 2'd3, 2'd1, 1'b0, 1'b0, "R4");
    send(24'h123456, 1, 2'd2, 2'd2, 1'b1, 1'b0, "R4 R5 R9");
    send(24'h7fffff, 1, 2'd1, 2'd0, 1'b1, 1'b1, "R4 R5 R9");
    send(24'hfedcba, 1, 2'd3, 2'd1, 1'b1, 1'b1, "R5 R9");
    send(24'h0f0f0f, 1, 2'd0, 2'd2, 1'b0, 1'b0, "R5 R6 R9");
    // R8 underrun: sample_i ignored, formatted zero sent
    send(24'haaaaaa, 0, 2'd0, 2'd3, 1'b0, 1'b1, "R8");
    send(24'h555555, 0, 2'd3, 2'd2, 1'b1, 1'b0, "R8");
    send(24'h800000, 1, 2'd3, 2'd3, 1'b0, 1'b0, "R6 R7");
    valid_i = 1'b0;
    wait (done == pushed);
    repeat (4) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule